// File: doc/BRIEF.md
# AHB Subordinate Transfer Commit Front-End

This block sits at the bus edge of an AHB subordinate. In every address phase it decides whether a real access is committed to this subordinate. A commit needs three things in the same cycle: the transfer type marks a real beat, the select is high, and the bus is advancing. When the phase commits, the block registers the address, the direction and the size. It then raises a one-cycle access strobe during the following data phase, which the storage behind it uses to act.

Non-transfer cycles (idle and busy) never start an access, even when the subordinate is selected. The response is always a zero-wait OKAY. The block also keeps a burst-context flag for prefetch logic downstream. A busy pause leaves the flag set, while an idle cycle or a deselected advancing cycle clears it. A committed sequential beat that arrives while that context is live is marked as predictable.

Top module: `ahb_commit_front`

## Requirements
- R1: When `hsel`=1, `hready`=1 and `htrans` is NONSEQ (2'b10) or SEQ (2'b11) at a rising edge, `acc_strobe` is 1 in the cycle that follows.
- R2: An address phase with `htrans` IDLE (2'b00) or BUSY (2'b01) gives `acc_strobe`=0 in the next cycle, whatever the state of `hsel`.
- R3: An address phase with `hsel`=0 or `hready`=0 gives `acc_strobe`=0 in the next cycle.
- R4: `acc_addr`, `acc_write` and `acc_size` take the `haddr`, `hwrite` and `hsize` of each committed address phase. They hold those values until the next commit.
- R5: `hreadyout` is 1 and `hresp` is 0 (OKAY) in every cycle, including the cycles after non-committed address phases.
- R6: With `hsel`=1 and `hready`=1, NONSEQ or SEQ sets `burst_active` at the next edge, BUSY leaves it unchanged, and IDLE clears it.
- R7: `hsel`=0 with `hready`=1 clears `burst_active` at the next edge.
- R8: `hready`=0 leaves `burst_active` unchanged, whatever the values of `htrans` and `hsel`.
- R9: `acc_seq` is 1 in a strobe cycle only when the committed beat was SEQ and `burst_active` was already 1 during its address phase. In every other cycle it is 0.
- R10: While `rst` is high and in the first cycle after it falls, `acc_strobe`, `acc_seq`, `burst_active` and `hresp` are 0 and `hreadyout` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| hsel | input | 1 | Subordinate select |
| htrans | input | 2 | Transfer type |
| haddr | input | ADDR_W | Address of the address phase |
| hwrite | input | 1 | Direction, 1 = write |
| hsize | input | 3 | Transfer size |
| hready | input | 1 | Bus advancing |
| hreadyout | output | 1 | Ready response of this subordinate |
| hresp | output | 1 | Response, 0 = OKAY |
| acc_strobe | output | 1 | Committed access, data phase |
| acc_addr | output | ADDR_W | Latched address |
| acc_write | output | 1 | Latched direction |
| acc_size | output | 3 | Latched size |
| acc_seq | output | 1 | Beat is a predictable continuation |
| burst_active | output | 1 | Burst context is live |

## Verification
The bench goes after phantom accesses: IDLE and BUSY while selected, and a real transfer type while deselected or stalled. A design that qualified on the transfer type alone would strobe in those cycles. It runs a burst with a BUSY pause and checks that the pause neither strobes nor drops the context, and that the SEQ after it is still flagged as predictable. A design that treated BUSY like IDLE would lose that flag. It also checks that a stalled IDLE does not clear the context. It sends a SEQ with no live context, which must commit but not be flagged. Finally it asserts reset in the middle of a burst and checks that the latched fields hold across non-committed cycles.

// File: rtl/ahb_commit_pkg.sv
package ahb_commit_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam int SIZE_W = 3;
  localparam logic RESP_OKAY = 1'b0;
endpackage

// File: rtl/ahb_commit_decode.sv
module ahb_commit_decode
  import ahb_commit_pkg::*;
(
  input  logic       sel_i,
  input  logic       rdy_i,
  input  logic [1:0] trans_i,
  input  logic       ctx_i,
  output logic       commit_o,
  output logic       predict_o
);
  logic real_beat;

  always_comb begin
    real_beat = (trans_i == TR_NONSEQ) || (trans_i == TR_SEQ);
    commit_o  = sel_i && rdy_i && real_beat;
    predict_o = commit_o && (trans_i == TR_SEQ) && ctx_i;
  end
endmodule

// File: rtl/ahb_burst_track.sv
module ahb_burst_track
  import ahb_commit_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_i,
  input  logic       rdy_i,
  input  logic [1:0] trans_i,
  output logic       active_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
    end else if (rdy_i) begin
      if (!sel_i) begin
        active_o <= 1'b0;
      end else begin
        case (trans_i)
          TR_IDLE:   active_o <= 1'b0;
          TR_BUSY:   active_o <= active_o;
          default:   active_o <= 1'b1;
        endcase
      end
    end
  end

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (rdy_i && sel_i && trans_i == TR_BUSY) |=> $stable(active_o));
  assert_idle_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (rdy_i && sel_i && trans_i == TR_IDLE) |=> !active_o);
  assert_unsel_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (rdy_i && !sel_i) |=> !active_o);
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!rdy_i) |=> $stable(active_o));
endmodule

// File: rtl/ahb_phase_latch.sv
module ahb_phase_latch #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_i,
  input  logic              predict_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              strobe_o,
  output logic              seq_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              write_o,
  output logic [SIZE_W-1:0] size_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_o <= 1'b0;
      seq_o    <= 1'b0;
    end else begin
      strobe_o <= commit_i;
      seq_o    <= predict_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o  <= '0;
      write_o <= 1'b0;
      size_o  <= '0;
    end else if (commit_i) begin
      addr_o  <= addr_i;
      write_o <= write_i;
      size_o  <= size_i;
    end
  end

  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    commit_i |=> (addr_o == $past(addr_i) && write_o == $past(write_i)
                  && size_o == $past(size_i)));
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> ($stable(addr_o) && $stable(write_o) && $stable(size_o)));
endmodule

// File: rtl/ahb_commit_front.sv
module ahb_commit_front
  import ahb_commit_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsel,
  input  logic [1:0]        htrans,
  input  logic [ADDR_W-1:0] haddr,
  input  logic              hwrite,
  input  logic [SIZE_W-1:0] hsize,
  input  logic              hready,
  output logic              hreadyout,
  output logic              hresp,
  output logic              acc_strobe,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_write,
  output logic [SIZE_W-1:0] acc_size,
  output logic              acc_seq,
  output logic              burst_active
);
  logic commit;
  logic predict;

  ahb_commit_decode u_decode (
    .sel_i     (hsel),
    .rdy_i     (hready),
    .trans_i   (htrans),
    .ctx_i     (burst_active),
    .commit_o  (commit),
    .predict_o (predict)
  );

  ahb_burst_track u_track (
    .clk      (clk),
    .rst      (rst),
    .sel_i    (hsel),
    .rdy_i    (hready),
    .trans_i  (htrans),
    .active_o (burst_active)
  );

  ahb_phase_latch #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .commit_i  (commit),
    .predict_i (predict),
    .addr_i    (haddr),
    .write_i   (hwrite),
    .size_i    (hsize),
    .strobe_o  (acc_strobe),
    .seq_o     (acc_seq),
    .addr_o    (acc_addr),
    .write_o   (acc_write),
    .size_o    (acc_size)
  );

  // Zero-wait responder: every phase, committed or not, answers OKAY at once.
  always_ff @(posedge clk) begin
    if (rst) begin
      hreadyout <= 1'b1;
      hresp     <= RESP_OKAY;
    end else begin
      hreadyout <= 1'b1;
      hresp     <= RESP_OKAY;
    end
  end

  assert_commit_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    (hsel && hready && htrans[1]) |=> acc_strobe);
  assert_nontransfer_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (htrans == TR_IDLE || htrans == TR_BUSY) |=> !acc_strobe);
  assert_unselected_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (!hsel || !hready) |=> !acc_strobe);
  assert_okay_resp_R5: assert property (@(posedge clk) disable iff (rst)
    hreadyout && hresp == RESP_OKAY);
  assert_nonseq_unflagged_R9: assert property (@(posedge clk) disable iff (rst)
    (htrans == TR_NONSEQ || !burst_active) |=> !acc_seq);
  assert_seq_only_with_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    acc_seq |-> acc_strobe);
  assert_reset_state_R10: assert property (@(posedge clk)
    $past(rst) |-> (!acc_strobe && !acc_seq && !burst_active && hreadyout && !hresp));
endmodule

// File: tb/ahb_commit_front_test.sv
`timescale 1ns/1ps
module ahb_commit_front_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        hsel;
  logic [1:0]  htrans;
  logic [31:0] haddr;
  logic        hwrite;
  logic [2:0]  hsize;
  logic        hready;
  logic        hreadyout, hresp, acc_strobe, acc_write, acc_seq, burst_active;
  logic [31:0] acc_addr;
  logic [2:0]  acc_size;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_addr = '0;
  logic        exp_wr = 1'b0;
  logic [2:0]  exp_sz = '0;

  always #2.5 clk = ~clk;

  ahb_commit_front #(.ADDR_W(32)) uut (
    .clk(clk), .rst(rst), .hsel(hsel), .htrans(htrans), .haddr(haddr),
    .hwrite(hwrite), .hsize(hsize), .hready(hready), .hreadyout(hreadyout),
    .hresp(hresp), .acc_strobe(acc_strobe), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_size(acc_size), .acc_seq(acc_seq),
    .burst_active(burst_active)
  );

  // {sel, rdy, trans, write, size, addr[15:0], exp strobe, exp seq, exp burst}
  localparam int NV = 16;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 1'b1, 2'b00, 1'b0, 3'd2, 16'h0000, 3'b000},
    {1'b1, 1'b1, 2'b10, 1'b1, 3'd2, 16'h0100, 3'b101},
    {1'b1, 1'b1, 2'b11, 1'b1, 3'd2, 16'h0104, 3'b111},
    {1'b1, 1'b1, 2'b01, 1'b1, 3'd2, 16'h0108, 3'b001},
    {1'b1, 1'b1, 2'b11, 1'b1, 3'd2, 16'h0108, 3'b111},
    {1'b1, 1'b0, 2'b11, 1'b1, 3'd2, 16'h010C, 3'b001},
    {1'b1, 1'b1, 2'b11, 1'b1, 3'd2, 16'h010C, 3'b111},
    {1'b1, 1'b1, 2'b00, 1'b0, 3'd0, 16'h0110, 3'b000},
    {1'b1, 1'b1, 2'b11, 1'b0, 3'd1, 16'h0200, 3'b101},
    {1'b0, 1'b1, 2'b11, 1'b1, 3'd1, 16'h0202, 3'b000},
    {1'b1, 1'b1, 2'b01, 1'b1, 3'd2, 16'h0300, 3'b000},
    {1'b1, 1'b1, 2'b10, 1'b0, 3'd0, 16'h0301, 3'b101},
    {1'b1, 1'b0, 2'b00, 1'b1, 3'd2, 16'h0302, 3'b001},
    {1'b1, 1'b1, 2'b10, 1'b1, 3'd2, 16'h0400, 3'b101},
    {1'b0, 1'b0, 2'b10, 1'b0, 3'd1, 16'h0500, 3'b001},
    {1'b1, 1'b1, 2'b00, 1'b0, 3'd0, 16'h0600, 3'b000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic r, input logic [1:0] t,
                       input logic w, input logic [2:0] z, input logic [15:0] a);
    hsel = s; hready = r; htrans = t; hwrite = w; hsize = z; haddr = {16'h0, a};
  endtask

  initial begin
    #(5.0 * 5000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(1'b0, 1'b1, 2'b00, 1'b0, 3'd0, 16'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: state while reset is held
    check("R10 strobe", {31'b0, acc_strobe}, 32'd0);
    check("R10 burst", {31'b0, burst_active}, 32'd0);
    check("R10 ready", {31'b0, hreadyout}, 32'd1);
    check("R10 resp", {31'b0, hresp}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      drive(v[26], v[25], v[24:23], v[22], v[21:19], v[18:3]);
      @(posedge clk);
      @(negedge clk);
      if (v[2]) begin
        exp_addr = v[18:3];
        exp_wr = v[22];
        exp_sz = v[21:19];
      end
      check("R1 R2 R3 strobe", {31'b0, acc_strobe}, {31'b0, v[2]});
      check("R9 seq flag", {31'b0, acc_seq}, {31'b0, v[1]});
      check("R6 R7 R8 burst", {31'b0, burst_active}, {31'b0, v[0]});
      check("R4 addr", acc_addr, {16'h0, exp_addr});
      check("R4 write", {31'b0, acc_write}, {31'b0, exp_wr});
      check("R4 size", {29'b0, acc_size}, {29'b0, exp_sz});
      check("R5 ready", {31'b0, hreadyout}, 32'd1);
      check("R5 resp", {31'b0, hresp}, 32'd0);
    end

    // R10: reset in the middle of a live burst
    drive(1'b1, 1'b1, 2'b10, 1'b1, 3'd2, 16'h0700);
    @(posedge clk);
    @(negedge clk);
    check("R6 burst set", {31'b0, burst_active}, 32'd1);
    rst = 1'b1;
    drive(1'b1, 1'b1, 2'b11, 1'b1, 3'd2, 16'h0704);
    @(posedge clk);
    @(negedge clk);
    check("R10 strobe in reset", {31'b0, acc_strobe}, 32'd0);
    check("R10 seq in reset", {31'b0, acc_seq}, 32'd0);
    check("R10 burst cleared", {31'b0, burst_active}, 32'd0);
    rst = 1'b0;
    drive(1'b1, 1'b1, 2'b00, 1'b0, 3'd0, 16'h0);
    @(posedge clk);
    @(negedge clk);
    check("R10 first cycle after reset", {31'b0, acc_strobe}, 32'd0);
    check("R2 idle after reset burst", {31'b0, burst_active}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule